// File: doc/BRIEF.md
# Graphics DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a graphics DRAM interface. It takes the memory from a cold, held-in-reset state to a state where normal traffic can begin. A single start pulse launches a fixed walk. The walk holds the device reset and clock enable low through a stable-power wait and a stable-clock wait. It then releases reset while the clock enable carries a strap level that picks the address/command termination, and raises the clock enable. After that it issues a precharge of all banks, an extended-mode write that turns the DLL on, a mode write that resets the DLL and loads the operating parameters, a long DLL lock wait, a second precharge-all and two auto refreshes. A done flag marks the end.

Every wait is a parameter counted in clock cycles, so a fast bench can shrink it and silicon can use the real microsecond values. The strap level and both mode words are captured on the start pulse. Every pin on the DRAM side comes from a register.

Top module: `dram_init_seq`

## Requirements
- R1: During and after reset, until a start pulse arrives, `dram_rst_n_o` and `cke_o` are low. The command pins show deselect (`cs_n_o`, `ras_n_o`, `cas_n_o` and `we_n_o` all 1), `ba_o` and `addr_o` are zero, and `done_o` is low.
- R2: For the first `T_PWR` cycles after the start pulse is registered, the pins hold reset low, clock enable low and deselect.
- R3: For the next `T_STAB` cycles, reset stays low, the bus shows deselect, and `cke_o` carries the termination strap captured at start. On the cycle `dram_rst_n_o` first goes high, `cke_o` still equals that strap and the bus shows NOP. On the following cycle `cke_o` is 1.
- R4: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: mode/extended-mode write = 0000, precharge = 0010, auto refresh = 0001, NOP = 0111. Every cycle that carries no command shows NOP once reset has risen. Every command is issued with reset and clock enable high.
- R5: The first precharge-all comes two cycles after reset rises. It has address bit 8 set, all other address bits zero and bank 0.
- R6: The extended-mode write comes `T_RP`+1 cycles after the first precharge, with bank = 01. Its address is the extended word captured at start with bit 6 forced to 0, which enables the DLL.
- R7: The mode write comes `T_MRD`+1 cycles after the extended-mode write, with bank = 00. Its address is the mode word captured at start with bit 8 forced to 1, which resets the DLL.
- R8: The second precharge-all comes `T_DLL`+1 cycles after the mode write. The first refresh comes `T_RP`+1 cycles after that precharge, and the second refresh comes `T_RFC`+1 cycles after the first. Refreshes carry zero bank and address.
- R9: `done_o` rises `T_RFC`+1 cycles after the second refresh. From then until reset it stays high, with reset and clock enable high and NOP on the bus.
- R10: A start pulse while the walk is running or after it has finished has no effect. Changes to the strap or mode-word inputs after the start pulse have no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches the walk when idle |
| term_sel_i | input | 1 | Termination strap; level driven on CKE when reset rises |
| mode_word_i | input | AW | Operating word for the mode write |
| ext_word_i | input | AW | Word for the extended-mode write |
| dram_rst_n_o | output | 1 | DRAM reset, active low |
| cke_o | output | 1 | DRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BAW | Bank address |
| addr_o | output | AW | Address / op-code |
| done_o | output | 1 | Walk finished; stays high until reset |

## Verification
The bench compares every pin on every cycle of each walk against a schedule it builds from the parameters. An off-by-one in any wait shows up as a command landing one cycle early or late. If the strap were sampled late, or the clock enable were raised together with reset, the wrong termination would show at the reset edge. Directed runs use mode and extended words of all zeros and all ones, so a forced DLL bit that does not override the word is caught. Later runs pulse start and scramble the strap and words mid-walk and after done. A design that restarted or re-latched its inputs would drift from the schedule.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_PWR, ST_STAB, ST_RST_RISE, ST_CKE_UP,
    ST_PREA1, ST_W_RP1, ST_EMRS, ST_W_MRD, ST_MRS, ST_W_DLL,
    ST_PREA2, ST_W_RP2, ST_REF1, ST_W_RFC1, ST_REF2, ST_W_RFC2, ST_DONE
  } init_state_e;

  typedef enum logic [2:0] {
    K_DESEL, K_NOP, K_PREA, K_EMRS, K_MRS, K_REF
  } cmd_kind_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] ENC_MODE  = 4'b0000;
  localparam logic [3:0] ENC_PRE   = 4'b0010;
  localparam logic [3:0] ENC_REF   = 4'b0001;
  localparam logic [3:0] ENC_NOP   = 4'b0111;
  localparam logic [3:0] ENC_DESEL = 4'b1111;

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R8

  AST_TMR_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

endmodule

// File: rtl/init_cmd_encoder.sv
module init_cmd_encoder
  import dram_init_pkg::*;
#(
  parameter int AW             = 12,
  parameter int BAW            = 2,
  parameter int AP_BIT         = 8,
  parameter int MR_DLL_RST_BIT = 8,
  parameter int EXT_DLL_BIT    = 6,
  parameter bit EXT_DLL_ON     = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  cmd_kind_e      kind_i,
  input  logic           rst_pin_d_i,
  input  logic           cke_d_i,
  input  logic           done_d_i,
  input  logic [AW-1:0]  mode_word_i,
  input  logic [AW-1:0]  ext_word_i,
  output logic           dram_rst_n_o,
  output logic           cke_o,
  output logic           cs_n_o,
  output logic           ras_n_o,
  output logic           cas_n_o,
  output logic           we_n_o,
  output logic [BAW-1:0] ba_o,
  output logic [AW-1:0]  addr_o,
  output logic           done_o
);

  logic [3:0]     enc_d;
  logic [BAW-1:0] ba_d;
  logic [AW-1:0]  addr_d;

  always_comb begin
    enc_d  = ENC_NOP;
    ba_d   = '0;
    addr_d = '0;
    case (kind_i)
      K_DESEL: enc_d = ENC_DESEL;
      K_NOP:   enc_d = ENC_NOP;
      K_PREA: begin
        enc_d          = ENC_PRE;
        addr_d[AP_BIT] = 1'b1;
      end
      K_EMRS: begin
        enc_d               = ENC_MODE;
        ba_d                = BAW'(1);
        addr_d              = ext_word_i;
        addr_d[EXT_DLL_BIT] = EXT_DLL_ON;
      end
      K_MRS: begin
        enc_d                  = ENC_MODE;
        addr_d                 = mode_word_i;
        addr_d[MR_DLL_RST_BIT] = 1'b1;
      end
      K_REF:   enc_d = ENC_REF;
      default: enc_d = ENC_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_rst_n_o <= 1'b0;
      cke_o        <= 1'b0;
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= ENC_DESEL;
      ba_o         <= '0;
      addr_o       <= '0;
      done_o       <= 1'b0;
    end else begin
      dram_rst_n_o <= rst_pin_d_i;
      cke_o        <= cke_d_i;
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= enc_d;
      ba_o         <= ba_d;
      addr_o       <= addr_d;
      done_o       <= done_d_i;
    end
  end

  AST_DONE_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!cs_n_o && ras_n_o && cas_n_o && we_n_o && cke_o)); // R9

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int AW             = 12,
  parameter int BAW            = 2,
  parameter int T_PWR          = 10000,
  parameter int T_STAB         = 20000,
  parameter int T_RP           = 2,
  parameter int T_MRD          = 2,
  parameter int T_RFC          = 8,
  parameter int T_DLL          = 20000,
  parameter int AP_BIT         = 8,
  parameter int MR_DLL_RST_BIT = 8,
  parameter int EXT_DLL_BIT    = 6,
  parameter bit EXT_DLL_ON     = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           term_sel_i,
  input  logic [AW-1:0]  mode_word_i,
  input  logic [AW-1:0]  ext_word_i,
  output logic           dram_rst_n_o,
  output logic           cke_o,
  output logic           cs_n_o,
  output logic           ras_n_o,
  output logic           cas_n_o,
  output logic           we_n_o,
  output logic [BAW-1:0] ba_o,
  output logic [AW-1:0]  addr_o,
  output logic           done_o
);

  localparam int M_A  = (T_PWR > T_STAB) ? T_PWR : T_STAB;
  localparam int M_B  = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int M_C  = (T_RFC > T_DLL) ? T_RFC : T_DLL;
  localparam int M_AB = (M_A > M_B) ? M_A : M_B;
  localparam int MAXW = (M_AB > M_C) ? M_AB : M_C;
  localparam int CW   = $clog2(MAXW + 1);

  init_state_e   state_q, state_d;
  logic          load;
  logic [CW-1:0] load_val;
  logic          expired;
  logic          term_q;
  logic [AW-1:0] mode_q, ext_q;
  cmd_kind_e     kind_d;
  logic          rst_pin_d, cke_d, done_d;

  init_wait_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .load_val_i(load_val),
    .expired_o (expired)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      ST_IDLE:     if (start_i) begin
                     state_d = ST_PWR;  load = 1'b1; load_val = CW'(T_PWR - 1);
                   end
      ST_PWR:      if (expired) begin
                     state_d = ST_STAB; load = 1'b1; load_val = CW'(T_STAB - 1);
                   end
      ST_STAB:     if (expired) state_d = ST_RST_RISE;
      ST_RST_RISE: state_d = ST_CKE_UP;
      ST_CKE_UP:   state_d = ST_PREA1;
      ST_PREA1:    begin state_d = ST_W_RP1;  load = 1'b1; load_val = CW'(T_RP - 1);  end
      ST_W_RP1:    if (expired) state_d = ST_EMRS;
      ST_EMRS:     begin state_d = ST_W_MRD;  load = 1'b1; load_val = CW'(T_MRD - 1); end
      ST_W_MRD:    if (expired) state_d = ST_MRS;
      ST_MRS:      begin state_d = ST_W_DLL;  load = 1'b1; load_val = CW'(T_DLL - 1); end
      ST_W_DLL:    if (expired) state_d = ST_PREA2;
      ST_PREA2:    begin state_d = ST_W_RP2;  load = 1'b1; load_val = CW'(T_RP - 1);  end
      ST_W_RP2:    if (expired) state_d = ST_REF1;
      ST_REF1:     begin state_d = ST_W_RFC1; load = 1'b1; load_val = CW'(T_RFC - 1); end
      ST_W_RFC1:   if (expired) state_d = ST_REF2;
      ST_REF2:     begin state_d = ST_W_RFC2; load = 1'b1; load_val = CW'(T_RFC - 1); end
      ST_W_RFC2:   if (expired) state_d = ST_DONE;
      ST_DONE:     state_d = ST_DONE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      term_q  <= 1'b0;
      mode_q  <= '0;
      ext_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        term_q <= term_sel_i;
        mode_q <= mode_word_i;
        ext_q  <= ext_word_i;
      end
    end
  end

  // Pin intent for the state being entered; registered in the encoder.
  always_comb begin
    kind_d    = K_NOP;
    rst_pin_d = 1'b1;
    cke_d     = 1'b1;
    done_d    = (state_d == ST_DONE);
    case (state_d)
      ST_IDLE, ST_PWR: begin kind_d = K_DESEL; rst_pin_d = 1'b0; cke_d = 1'b0;   end
      ST_STAB:         begin kind_d = K_DESEL; rst_pin_d = 1'b0; cke_d = term_q; end
      ST_RST_RISE:     cke_d  = term_q;
      ST_PREA1, ST_PREA2: kind_d = K_PREA;
      ST_EMRS:         kind_d = K_EMRS;
      ST_MRS:          kind_d = K_MRS;
      ST_REF1, ST_REF2: kind_d = K_REF;
      default:         kind_d = K_NOP;
    endcase
  end

  init_cmd_encoder #(
    .AW(AW), .BAW(BAW), .AP_BIT(AP_BIT), .MR_DLL_RST_BIT(MR_DLL_RST_BIT),
    .EXT_DLL_BIT(EXT_DLL_BIT), .EXT_DLL_ON(EXT_DLL_ON)
  ) u_enc (
    .clk         (clk),
    .rst         (rst),
    .kind_i      (kind_d),
    .rst_pin_d_i (rst_pin_d),
    .cke_d_i     (cke_d),
    .done_d_i    (done_d),
    .mode_word_i (mode_q),
    .ext_word_i  (ext_q),
    .dram_rst_n_o(dram_rst_n_o),
    .cke_o       (cke_o),
    .cs_n_o      (cs_n_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o),
    .ba_o        (ba_o),
    .addr_o      (addr_o),
    .done_o      (done_o)
  );

  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (!dram_rst_n_o && !cke_o && cs_n_o && !done_o)); // R1

  AST_PWR_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PWR) |-> (!dram_rst_n_o && !cke_o && cs_n_o)); // R2

  AST_STRAP_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_rst_n_o) |-> (cke_o == term_q)); // R3

  AST_CMD_LIVE: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && !(ras_n_o && cas_n_o && we_n_o)) |-> (cke_o && dram_rst_n_o)); // R4

  AST_CMD_SPACED: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && !(ras_n_o && cas_n_o && we_n_o)) |=> (ras_n_o && cas_n_o && we_n_o)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && start_i) |=> (state_q != ST_IDLE)); // R10

endmodule

// File: tb/dram_init_seq_tb_top.sv
module dram_init_seq_tb_top;

  localparam int AW  = 12;
  localparam int BAW = 2;
  localparam int P   = 5;
  localparam int S   = 7;
  localparam int RP  = 2;
  localparam int MRD = 3;
  localparam int RFC = 4;
  localparam int DLL = 20;
  localparam int A_I = P + S + 2;
  localparam int B_I = A_I + 1 + RP;
  localparam int C_I = B_I + 1 + MRD;
  localparam int D_I = C_I + 1 + DLL;
  localparam int E_I = D_I + 1 + RP;
  localparam int F_I = E_I + 1 + RFC;
  localparam int G_I = F_I + 1 + RFC;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           term_sel = 1'b0;
  logic [AW-1:0]  mode_w = '0;
  logic [AW-1:0]  ext_w = '0;
  logic           rst_n, cke, cs_n, ras_n, cas_n, we_n, done;
  logic [BAW-1:0] ba;
  logic [AW-1:0]  addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic           e_rst, e_cke, e_done;
  logic [3:0]     e_cmd;
  logic [BAW-1:0] e_ba;
  logic [AW-1:0]  e_addr;
  string          e_tag;

  always #5 clk = ~clk;

  dram_init_seq #(
    .AW(AW), .BAW(BAW), .T_PWR(P), .T_STAB(S), .T_RP(RP),
    .T_MRD(MRD), .T_RFC(RFC), .T_DLL(DLL)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .term_sel_i(term_sel),
    .mode_word_i(mode_w), .ext_word_i(ext_w),
    .dram_rst_n_o(rst_n), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .done_o(done)
  );

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual cycle %0d expected < 20000", cyc);
        summary_and_end();
      end
    end
  end

  // Expected pins at cycle i after the start edge, from the requirements.
  task automatic expect_at(input int i, input logic t, input logic [AW-1:0] mw,
                           input logic [AW-1:0] ew);
    e_rst = 1'b1; e_cke = 1'b1; e_cmd = 4'b0111; e_ba = '0; e_addr = '0;
    e_done = 1'b0; e_tag = "R8 R4";
    if (i < P) begin
      e_rst = 1'b0; e_cke = 1'b0; e_cmd = 4'b1111; e_tag = "R2";
    end else if (i < P + S) begin
      e_rst = 1'b0; e_cke = t; e_cmd = 4'b1111; e_tag = "R3";
    end else if (i == P + S) begin
      e_cke = t; e_tag = "R3";
    end else if (i == P + S + 1) begin
      e_tag = "R3";
    end else if (i == A_I || i == D_I) begin
      e_cmd = 4'b0010; e_addr = AW'(1) << 8; e_tag = (i == A_I) ? "R5 R4" : "R8 R4";
    end else if (i == B_I) begin
      e_cmd = 4'b0000; e_ba = 2'b01; e_addr = ew & ~(AW'(1) << 6); e_tag = "R6 R4";
    end else if (i == C_I) begin
      e_cmd = 4'b0000; e_ba = 2'b00; e_addr = mw | (AW'(1) << 8); e_tag = "R7 R4";
    end else if (i == E_I || i == F_I) begin
      e_cmd = 4'b0001; e_tag = "R8 R4";
    end else if (i >= G_I) begin
      e_done = 1'b1; e_tag = "R9";
    end
  endtask

  task automatic compare(input string tag);
    logic [20:0] act, exp;
    act = {rst_n, cke, cs_n, ras_n, cas_n, we_n, ba, addr, done};
    exp = {e_rst, e_cke, e_cmd, e_ba, e_addr, e_done};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pins actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic one_run(input int run);
    logic           t;
    logic [AW-1:0]  mw, ew;
    bit             disturb;
    t  = (run == 0) ? 1'b0 : (run == 1) ? 1'b1 : 1'($urandom % 2);
    mw = (run == 0) ? '0 : (run == 1) ? '1 : AW'($urandom);
    ew = (run == 0) ? '1 : (run == 1) ? '0 : AW'($urandom);
    disturb = (run >= 2);
    rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle until a start pulse
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expect_at(0, 1'b0, '0, '0);
      e_done = 1'b0;
      compare("R1");
    end
    term_sel = t; mode_w = mw; ext_w = ew; start = 1'b1;
    for (int i = 0; i <= G_I + 3; i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      expect_at(i, t, mw, ew);
      compare(e_tag);
      // R10: scramble inputs and pulse start mid-walk
      if (disturb && (i == 3 || i == P + S + 8)) begin
        start = 1'b1; term_sel = ~term_sel;
        mode_w = AW'($urandom); ext_w = AW'($urandom);
      end else begin
        start = 1'b0;
      end
    end
    // R10: start after done changes nothing
    start = 1'b1; term_sel = ~term_sel;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      expect_at(G_I + 10, t, mw, ew);
      compare("R10");
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int run = 0; run < 5; run++) one_run(run);
    summary_and_end();
  end

endmodule